// File: doc/BRIEF.md
# Cascadable Frame-Synchronised Serializer

The block turns a ten-bit parallel word into a serial bit stream, one bit per rising edge of a fast bit clock. A slower frame reference, sampled in the bit-clock domain, marks the start of each frame. The number of bits per frame, the ratio M, is programmable from 2 to 40. Each frame the block captures the parallel word, sends it least significant bit first, and drives a link clock that rises together with the frame and stays high for the first half of it. When M is above ten, the bits after the tenth come from a cascade serial input. That input is wired to the serial output of an upstream copy of the block, so two or more stages together can carry frames longer than ten bits.

A controller with three states sets the sequence. OFF is entered on reset and whenever `en` is low; it clears the datapath and holds every output at 0. OFF moves to WAIT on the first edge with `en` high. WAIT moves to SEND when a frame edge is detected. SEND stays in SEND and restarts the frame when a new frame edge arrives. SEND returns to WAIT once the last bit of the frame has been taken and no new frame edge is pending. Any state moves to OFF when `en` is low. The output enables are plain flags. `lclk_en` silences only the link clock, and `cas_en` forces the cascade input to 0.

Top module: `casc_serializer`

## Requirements
- R1: While `rst` is high at a clock edge, and directly after its release, `ser_out`, `ser_oe`, `lclk_out` and `lclk_oe` are 0.
- R2: The parallel word is captured only on the first bit-clock edge after frame detection (edge D+1, where D is the edge on which the second synchroniser flop first samples the reference high). Changes on `par_in` at any other edge do not alter the bits sent.
- R3: Bit 0 of the captured word is on `ser_out` after edge D+3. Bit j follows after edge D+3+j, in ascending index order.
- R4: For M of 10 or less, exactly bits 0 to M-1 are sent and the cascade input has no effect. When no new frame follows, `ser_out` returns to 0.
- R5: For M above 10, frame bits 10 to M-1 are the cascade input delayed by exactly ten bit-clock edges. With two chained stages sharing the frame reference, the downstream stage's bit 10+i equals the upstream stage's bit i.
- R6: While `cas_en` is low, every cascade bit of a frame (index 10 or above) is 0, whatever `cas_in` carries.
- R7: M is captured from `ratio` at the same edge as the parallel word and holds for the whole frame, even if `ratio` changes during the frame.
- R8: `lclk_out` rises after edge D+1. It stays high for ceil(M/2) edges and is low for the rest of the frame and while no frame is running.
- R9: While `lclk_en` is low, `lclk_out` and `lclk_oe` are 0 and the serial data is unaffected.
- R10: An edge with `en` low clears `ser_out`, `lclk_out`, `ser_oe` and `lclk_oe` to 0 and aborts the running frame. Frame edges whose capture edge falls while disabled are ignored. `ser_oe` follows `en` with one edge of delay, and `lclk_oe` follows `en` and `lclk_en` together.
- R11: Frame edges spaced exactly M bit-clock cycles apart give a continuous stream. The first bit of one frame directly follows the last bit of the previous one, with no gap, even when M changes from frame to frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Main enable |
| lclk_en | input | 1 | Link clock output enable |
| cas_en | input | 1 | Cascade input enable |
| frame_ref | input | 1 | Frame reference clock, sampled asynchronously |
| ratio | input | 6 | Bits per frame M (2 to 40) |
| par_in | input | 10 | Parallel data word |
| cas_in | input | 1 | Cascade serial input from the upstream stage |
| ser_out | output | 1 | Serial data output |
| ser_oe | output | 1 | Serial output valid flag |
| lclk_out | output | 1 | Link clock output |
| lclk_oe | output | 1 | Link clock valid flag |

## Verification
A wrong bit index or a mis-captured word appears on `ser_out` as a wrong or rotated bit as early as D+3, the first bit of the frame. An extra or missing synchroniser stage moves every bit and the link clock edge by one cycle in the first frame. A wrong cascade delay shows only at bit 10 of a chained frame, thirteen edges after detection. A wrong state transition shows as a gap or a repeated bit at the boundary between back-to-back frames, or as a link clock that is too wide. The sweeps cover every M from 2 to 10, many values above 10, gapped and back-to-back frames, and a disable in mid-frame, so each of these errors reaches the ports within one frame.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } cs_state_e;

endpackage

// File: rtl/cs_frame_detect.sv
`timescale 1ns/1ps
module cs_frame_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic edge_hit
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ref_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign edge_hit = sync_q[SYNC_STAGES-1] & ~prev_q;

    // R3
    hit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        edge_hit |=> !edge_hit);

endmodule

// File: rtl/cs_delay_line.sv
`timescale 1ns/1ps
module cs_delay_line #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic din,
    output logic dout
);

    logic [DEPTH-1:0] tap_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst || clr) tap_q[i] <= 1'b0;
                else            tap_q[i] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst || clr) tap_q[i] <= 1'b0;
                else            tap_q[i] <= tap_q[i-1];
            end
        end
    end

    assign dout = tap_q[DEPTH-1];

endmodule

// File: rtl/cs_shifter.sv
`timescale 1ns/1ps
module cs_shifter #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] din,
    output logic             lsb
);

    logic [WIDTH-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst || clr)  word_q <= '0;
        else if (load)   word_q <= din;
        else if (shift)  word_q <= {1'b0, word_q[WIDTH-1:1]};
    end

    assign lsb = word_q[0];

endmodule

// File: rtl/casc_serializer.sv
`timescale 1ns/1ps
module casc_serializer
    import cs_pkg::*;
#(
    parameter int PAR_W       = 10,
    parameter int RATIO_W     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               lclk_en,
    input  logic               cas_en,
    input  logic               frame_ref,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [PAR_W-1:0]   par_in,
    input  logic               cas_in,
    output logic               ser_out,
    output logic               ser_oe,
    output logic               lclk_out,
    output logic               lclk_oe
);

    // Cascade path plus take and output registers gives a PAR_W-edge delay.
    localparam int                 CAS_DELAY = PAR_W - 2;
    localparam logic [RATIO_W-1:0] PAR_LIMIT = RATIO_W'(PAR_W);
    localparam logic [RATIO_W-1:0] ONE       = RATIO_W'(1);

    cs_state_e          state_q, state_d;
    logic [RATIO_W-1:0] idx_q, idx_d;
    logic [RATIO_W-1:0] ratio_q, ratio_d;
    logic [RATIO_W:0]   ratio_sum;
    logic [RATIO_W-1:0] half_d;
    logic               frame_hit;
    logic               load, take, last_take;
    logic               sh_lsb, cas_bit, cas_tap, take_bit;
    logic               mid_q, ser_q, lclk_q, soe_q, loe_q;

    cs_frame_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .ref_in   (frame_ref),
        .edge_hit (frame_hit)
    );

    cs_shifter #(.WIDTH(PAR_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .clr   (!en),
        .load  (load),
        .shift (take && (idx_q < PAR_LIMIT)),
        .din   (par_in),
        .lsb   (sh_lsb)
    );

    // R6: a disabled cascade input contributes zeros.
    assign cas_bit = cas_en & cas_in;

    cs_delay_line #(.DEPTH(CAS_DELAY)) u_casdly (
        .clk  (clk),
        .rst  (rst),
        .clr  (!en),
        .din  (cas_bit),
        .dout (cas_tap)
    );

    assign load      = en && frame_hit && (state_q != ST_OFF);
    assign take      = en && (state_q == ST_SEND);
    assign last_take = (idx_q == (ratio_q - ONE));
    assign take_bit  = (idx_q < PAR_LIMIT) ? sh_lsb : cas_tap;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_WAIT;
                ST_WAIT: if (frame_hit) state_d = ST_SEND;
                ST_SEND: begin
                    if (frame_hit)      state_d = ST_SEND;
                    else if (last_take) state_d = ST_WAIT;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // Frame bookkeeping: bit index and captured ratio
    always_comb begin
        idx_d   = idx_q;
        ratio_d = ratio_q;
        if (!en) begin
            idx_d   = '0;
            ratio_d = '0;
        end else if (load) begin
            idx_d   = '0;
            ratio_d = ratio;
        end else if (take) begin
            idx_d   = idx_q + ONE;
        end
        ratio_sum = {1'b0, ratio_d} + {{RATIO_W{1'b0}}, 1'b1};
        half_d    = ratio_sum[RATIO_W:1];
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            idx_q   <= '0;
            ratio_q <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            ratio_q <= ratio_d;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mid_q  <= 1'b0;
            ser_q  <= 1'b0;
            lclk_q <= 1'b0;
            soe_q  <= 1'b0;
            loe_q  <= 1'b0;
        end else if (!en) begin
            mid_q  <= 1'b0;
            ser_q  <= 1'b0;
            lclk_q <= 1'b0;
            soe_q  <= 1'b0;
            loe_q  <= 1'b0;
        end else begin
            mid_q  <= take ? take_bit : 1'b0;
            ser_q  <= mid_q;
            lclk_q <= lclk_en && (state_d == ST_SEND) && (idx_d < half_d);
            soe_q  <= 1'b1;
            loe_q  <= lclk_en;
        end
    end

    assign ser_out  = ser_q;
    assign ser_oe   = soe_q;
    assign lclk_out = lclk_q;
    assign lclk_oe  = loe_q;

    // R8
    lclk_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lclk_out) |-> $past(frame_hit));

    // R9
    lclk_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !lclk_en |=> (!lclk_out && !lclk_oe));

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!ser_out && !lclk_out && !ser_oe && !lclk_oe));

    // R7
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEND) |-> (idx_q < ratio_q));

    // R11
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> ((state_q == ST_SEND) && (idx_q == '0)));

endmodule

// File: tb/casc_serializer_bench.sv
`timescale 1ns/1ps
module casc_serializer_bench;

    logic       clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1, en = 1'b0, lco_en = 1'b0, cas_en_dn = 1'b0;
    logic       fref = 1'b0, up_cin = 1'b0;
    logic [5:0] ratio = '0;
    logic [9:0] par_up = '0, par_dn = '0;
    logic       dn_ser, dn_soe, dn_lclk, dn_loe;
    logic       up_ser, up_soe, up_lclk, up_loe;

    casc_serializer u_casc_serializer (
        .clk(clk), .rst(rst), .en(en), .lclk_en(lco_en), .cas_en(cas_en_dn),
        .frame_ref(fref), .ratio(ratio), .par_in(par_dn), .cas_in(up_ser),
        .ser_out(dn_ser), .ser_oe(dn_soe), .lclk_out(dn_lclk), .lclk_oe(dn_loe)
    );

    casc_serializer u_upstream (
        .clk(clk), .rst(rst), .en(en), .lclk_en(lco_en), .cas_en(1'b0),
        .frame_ref(fref), .ratio(ratio), .par_in(par_up), .cas_in(up_cin),
        .ser_out(up_ser), .ser_oe(up_soe), .lclk_out(up_lclk), .lclk_oe(up_loe)
    );

    int         n_cmp = 0, n_bad = 0;
    bit         done = 1'b0;
    int         fa[16], fm[16];
    logic [9:0] fwu[16], fwd[16];
    int         nf;
    int         dlo, dhi, zlo, zhi;
    logic       e_dn[1024], e_up[1024], e_lc[1024];

    function automatic bit en_at(int e);
        return !(e >= dlo && e <= dhi);
    endfunction

    task automatic chk(string t, string what, int n, logic act, logic ex);
        n_cmp++;
        if (act !== ex) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d actual=%0b expected=%0b", t, what, n, act, ex);
        end
    endtask

    task automatic clear_cfg();
        nf = 0; dlo = 1000000; dhi = -1; zlo = 1; zhi = 0;
    endtask

    task automatic add(int a, int m);
        fa[nf]  = a;
        fm[nf]  = m;
        fwd[nf] = 10'(nf * 311 + m * 29 + 5);
        fwu[nf] = 10'(nf * 197 + m * 71 + 400);
        nf++;
    endtask

    task automatic build();
        for (int t = 0; t < 1024; t++) begin
            e_dn[t] = 1'b0; e_up[t] = 1'b0; e_lc[t] = 1'b0;
        end
        for (int f = 0; f < nf; f++) begin
            if (en_at(fa[f] + 2)) begin
                for (int j = 0; j < fm[f]; j++) begin
                    int t = fa[f] + 4 + j;
                    e_up[t] = (j < 10) ? fwu[f][j] : 1'b0;
                    if (j < 10)                       e_dn[t] = fwd[f][j];
                    else if (cas_en_dn && (j < 20))   e_dn[t] = fwu[f][j-10];
                    else                              e_dn[t] = 1'b0;
                end
                for (int t = fa[f] + 2; t < fa[f] + 2 + (fm[f] + 1) / 2; t++)
                    e_lc[t] = lco_en;
            end
        end
        for (int t = zlo; t <= zhi; t++) begin
            e_dn[t] = 1'b0; e_up[t] = 1'b0; e_lc[t] = 1'b0;
        end
    endtask

    task automatic run(string t, int len);
        build();
        @(negedge clk); rst = 1'b1; en = 1'b1; fref = 1'b0;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        for (int n = 0; n < len; n++) begin
            string tg, tl, to;
            int    e;
            logic  soe;
            bit    hi;
            tg  = (n == 0) ? "R1" : ((n >= zlo && n <= zhi) ? "R10" : t);
            tl  = (n == 0) ? "R1" : (lco_en ? "R8" : "R9");
            to  = (n == 0) ? "R1" : "R10";
            soe = (n == 0) ? 1'b0 : en_at(n);
            chk(tg, "dn_ser", n, dn_ser, e_dn[n]);
            chk(tg, "up_ser", n, up_ser, e_up[n]);
            chk(tl, "dn_lclk", n, dn_lclk, e_lc[n]);
            chk(tl, "up_lclk", n, up_lclk, e_lc[n]);
            chk(to, "ser_oe", n, dn_soe, soe);
            chk(to, "lclk_oe", n, dn_loe, soe & lco_en);
            // drive inputs for edge n+1
            e      = n + 1;
            en     = en_at(e);
            hi     = 1'b0;
            par_dn = 10'(e * 173 + 91);
            par_up = 10'(e * 59 + 300);
            ratio  = 6'(2 + (e * 7) % 39);
            for (int f = 0; f < nf; f++) begin
                if (e >= fa[f] && e < fa[f] + fm[f] / 2) hi = 1'b1;
                if (e == fa[f] + 2) begin
                    par_dn = fwd[f];
                    par_up = fwu[f];
                    ratio  = 6'(fm[f]);
                end
            end
            fref = hi;
            @(negedge clk);
        end
    endtask

    initial begin
        int a;
        lco_en = 1'b1; cas_en_dn = 1'b1; up_cin = 1'b1;

        // R4: every ratio 2..10, two frames each, back to back
        clear_cfg(); a = 2;
        for (int m = 2; m <= 10; m++) begin
            add(a, m); add(a + m, m); a += 2 * m;
        end
        run("R4", a + 12);

        // R5: chained stages at M = 20
        clear_cfg(); a = 2;
        for (int k = 0; k < 4; k++) begin add(a, 20); a += 20; end
        run("R5", a + 12);

        // R7: ratio changes frame to frame above ten
        clear_cfg(); a = 2;
        add(a, 11); a += 11; add(a, 15); a += 15; add(a, 19); a += 19;
        add(a, 21); a += 21; add(a, 30); a += 30; add(a, 40); a += 40;
        add(a, 13); a += 13;
        run("R7", a + 12);

        // R6: cascade disabled on the downstream stage
        cas_en_dn = 1'b0;
        clear_cfg(); a = 2;
        add(a, 20); a += 20; add(a, 30); a += 30; add(a, 12); a += 12;
        run("R6", a + 12);
        cas_en_dn = 1'b1;

        // R2 with R9: link clock off, garbage on par_in between captures
        lco_en = 1'b0;
        clear_cfg(); a = 2;
        add(a, 7); a += 7; add(a, 12); a += 12; add(a, 25); a += 25;
        run("R2", a + 12);
        lco_en = 1'b1;

        // R10: disable in mid-frame, a frame while disabled, then recovery
        clear_cfg();
        add(2, 12); add(14, 12); add(24, 12); add(40, 12);
        dlo = 20; dhi = 30; zlo = 20; zhi = 41;
        run("R10", 64);

        // R3: frames separated by idle gaps
        clear_cfg();
        add(2, 10); add(30, 4); add(60, 16);
        run("R3", 90);

        // R11: back-to-back frames with mixed small and large ratios
        clear_cfg(); a = 2;
        add(a, 3); a += 3; add(a, 40); a += 40; add(a, 2); a += 2;
        add(a, 25); a += 25; add(a, 5); a += 5;
        run("R11", a + 12);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule